// File: doc/BRIEF.md
# Instruction Trace Packet Encoder

This block watches the stream of retirement events that a processor core reports, one per cycle at most, and turns it into compact trace packets on a valid/ready output stream. Each event is one of eight kinds: execute, stall, taken branch (with its target address), exception (with its identifier), exception return, wait, stop, or instruction-cache miss (with the missed address). A format selector decides which kinds are recorded. The full format rebuilds execution history and timing, the branch format keeps only taken branches, and the icache format keeps only cache misses. A trace-active input gates recording. When tracing switches off, a closing packet marks the end of the trace.

Every packet carries a 2-bit primary identifier, a 4-bit subtype that is used only by extended packets, and a data field of PC_W-1 bits. Addresses are truncated to a programmable number of bits, and address bit 0 is never recorded. The event side is back-pressured through `ev_ready`. An event moves only in a cycle where `ev_valid` and `ev_ready` are both high. The core must hold its event while `ev_ready` is low, so no event is lost. The packet side follows the usual rule: a packet moves on a cycle with `pkt_valid` and `pkt_ready` both high. Once a packet is offered, it does not change or retract until it is taken. A single output register buffers one packet. While that register is occupied and not being drained, `ev_ready` is low.

Top module: `trc_encoder`

## Requirements
- R1: After reset, `pkt_valid` is 0 and, with no event offered, `ev_ready` is 1.
- R2: Primary identifiers are 0 execute, 1 stall, 2 branch and 3 extended. In full format an execute event yields identifier 0 with data 0. A non-extended packet always has subtype 0.
- R3: A branch packet (identifier 2) carries target address bits [n:1], zero-extended, where n is `cfg_pc_bits`. A value of 0 in `cfg_pc_bits` acts as 1.
- R4: In full format, the following events each yield an extended packet with a distinct subtype: an exception (subtype 1, data = identifier), an exception return (2), a stop (3) and a wait (4). Cache misses are consumed and yield nothing in full format.
- R5: In full format, stall events yield no packet of their own. A run of N stalls yields one extended count packet (subtype 6, data N). It is emitted before the next non-stall event is taken, or before the end packet. When the run reaches 2^CNT_W-1, the count packet is emitted at once and counting restarts.
- R6: Format code 1 (branch) records only taken branches. Every other event is consumed and yields nothing.
- R7: Format code 2 (icache) records only cache misses, as an extended PC packet (subtype 7) that carries the truncated missed address. Every other event is consumed and yields nothing.
- R8: While `trace_active` is low, events are consumed and yield no packet. A stall seen while inactive does not count toward a later count packet.
- R9: When `trace_active` falls, one end packet follows. It is subtype 10 carrying the last recorded address if an address packet was produced since the previous end packet, and subtype 9 with data 0 otherwise.
- R10: While `pkt_valid` is high and `pkt_ready` is low, the packet fields hold steady and `ev_ready` is low. Packets leave in event order and none is lost.
- R11: Format code 3 is reserved and records no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fmt | input | 2 | Format: 0 full, 1 branch, 2 icache, 3 reserved |
| cfg_pc_bits | input | $clog2(PC_W) | Number of address bits recorded, counted from bit 1 |
| trace_active | input | 1 | Recording enabled; a falling edge closes the trace |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event taken this cycle when both are high |
| ev_kind | input | 3 | 0 execute, 1 stall, 2 branch, 3 exception, 4 return, 5 wait, 6 stop, 7 cache miss |
| ev_addr | input | PC_W-1 | Address bits [PC_W-1:1] of the branch target or missed address |
| ev_eid | input | EID_W | Exception identifier |
| pkt_valid | output | 1 | Packet offered |
| pkt_ready | input | 1 | Sink accepts the packet |
| pkt_id | output | 2 | Primary identifier |
| pkt_sub | output | 4 | Extended subtype |
| pkt_data | output | PC_W-1 | Packet payload |

## Verification
The bench builds the encoder with a 32-bit PC, an 8-bit exception identifier and a 3-bit stall counter. The narrow counter lets a run of seven stalls reach the early count flush in a few cycles. The full PC width lets the truncation checks cover every setting from the 0-as-1 clamp up to 31 bits. Holding the sink's ready low brings the blocked-event path and the held-packet path within reach.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [2:0] {
    EV_EXEC   = 3'd0,
    EV_STALL  = 3'd1,
    EV_BRANCH = 3'd2,
    EV_EXC    = 3'd3,
    EV_ERET   = 3'd4,
    EV_WAIT   = 3'd5,
    EV_STOP   = 3'd6,
    EV_IMISS  = 3'd7
  } ev_kind_e;

  typedef enum logic [1:0] {
    FMT_FULL   = 2'd0,
    FMT_BRANCH = 2'd1,
    FMT_ICACHE = 2'd2,
    FMT_RSVD   = 2'd3
  } fmt_e;

  localparam logic [1:0] PID_EXEC   = 2'd0;
  localparam logic [1:0] PID_STALL  = 2'd1;
  localparam logic [1:0] PID_BRANCH = 2'd2;
  localparam logic [1:0] PID_EXT    = 2'd3;

  // extended subtypes; numbering is decoded downstream
  localparam logic [3:0] SUB_NONE   = 4'd0;
  localparam logic [3:0] SUB_EXC    = 4'd1;
  localparam logic [3:0] SUB_ERET   = 4'd2;
  localparam logic [3:0] SUB_STOP   = 4'd3;
  localparam logic [3:0] SUB_WAIT   = 4'd4;
  localparam logic [3:0] SUB_MCYC   = 4'd5;
  localparam logic [3:0] SUB_COUNT  = 4'd6;
  localparam logic [3:0] SUB_PC     = 4'd7;
  localparam logic [3:0] SUB_INDIR  = 4'd8;
  localparam logic [3:0] SUB_END    = 4'd9;
  localparam logic [3:0] SUB_END_PC = 4'd10;

endpackage

// File: rtl/trc_pc_trunc.sv
module trc_pc_trunc #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:1]         addr_hi,
  input  logic [$clog2(PC_W)-1:0] pc_bits,
  output logic [PC_W-2:0]         trunc
);
  localparam int DW = PC_W - 1;

  logic [DW-1:0] mask;
  int            eff;

  always_comb begin
    eff = (pc_bits == '0) ? 1 : int'(pc_bits);
    for (int i = 0; i < DW; i++) begin
      mask[i] = (i < eff);
    end
  end

  assign trunc = addr_hi & mask;

endmodule

// File: rtl/trc_classify.sv
module trc_classify
  import trc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int EID_W = 8
) (
  input  logic [1:0]              fmt,
  input  logic [2:0]              kind,
  input  logic [PC_W-1:1]         addr_hi,
  input  logic [EID_W-1:0]        eid,
  input  logic [$clog2(PC_W)-1:0] pc_bits,
  output logic                    keep,
  output logic                    is_stall,
  output logic                    has_addr,
  output logic [1:0]              id,
  output logic [3:0]              sub,
  output logic [PC_W-2:0]         data
);
  localparam int DW = PC_W - 1;

  logic [DW-1:0] addr_t;
  logic [DW-1:0] eid_x;

  trc_pc_trunc #(.PC_W(PC_W)) u_trunc (
    .addr_hi (addr_hi),
    .pc_bits (pc_bits),
    .trunc   (addr_t)
  );

  assign eid_x = {{(DW-EID_W){1'b0}}, eid};

  always_comb begin
    keep     = 1'b0;
    is_stall = 1'b0;
    has_addr = 1'b0;
    id       = PID_EXEC;
    sub      = SUB_NONE;
    data     = '0;
    case (fmt)
      FMT_FULL: begin
        case (kind)
          EV_EXEC:   keep = 1'b1;
          EV_STALL:  is_stall = 1'b1;
          EV_BRANCH: begin keep = 1'b1; id = PID_BRANCH; data = addr_t; has_addr = 1'b1; end
          EV_EXC:    begin keep = 1'b1; id = PID_EXT; sub = SUB_EXC; data = eid_x; end
          EV_ERET:   begin keep = 1'b1; id = PID_EXT; sub = SUB_ERET; end
          EV_WAIT:   begin keep = 1'b1; id = PID_EXT; sub = SUB_WAIT; end
          EV_STOP:   begin keep = 1'b1; id = PID_EXT; sub = SUB_STOP; end
          default:   ;
        endcase
      end
      FMT_BRANCH: begin
        if (kind == EV_BRANCH) begin
          keep = 1'b1; id = PID_BRANCH; data = addr_t; has_addr = 1'b1;
        end
      end
      FMT_ICACHE: begin
        if (kind == EV_IMISS) begin
          keep = 1'b1; id = PID_EXT; sub = SUB_PC; data = addr_t; has_addr = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // R6 / R7: a narrowed format never lets a foreign packet kind through
  always_comb begin
    if (keep && fmt == FMT_BRANCH)
      assert_branch_only_R6: assert (id == PID_BRANCH);
    if (keep && fmt == FMT_ICACHE)
      assert_icache_only_R7: assert (id == PID_EXT && sub == SUB_PC && has_addr);
  end

endmodule

// File: rtl/trc_out_reg.sv
module trc_out_reg #(
  parameter int DW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    in_id,
  input  logic [3:0]    in_sub,
  input  logic [DW-1:0] in_data,
  output logic          slot_free,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_id,
  output logic [3:0]    out_sub,
  output logic [DW-1:0] out_data
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_id    <= '0;
      out_sub   <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_id    <= in_id;
      out_sub   <= in_sub;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_id) && $stable(out_sub) && $stable(out_data)));

endmodule

// File: rtl/trc_encoder.sv
module trc_encoder
  import trc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int EID_W = 8,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              cfg_fmt,
  input  logic [$clog2(PC_W)-1:0] cfg_pc_bits,
  input  logic                    trace_active,
  input  logic                    ev_valid,
  output logic                    ev_ready,
  input  logic [2:0]              ev_kind,
  input  logic [PC_W-1:1]         ev_addr,
  input  logic [EID_W-1:0]        ev_eid,
  output logic                    pkt_valid,
  input  logic                    pkt_ready,
  output logic [1:0]              pkt_id,
  output logic [3:0]              pkt_sub,
  output logic [PC_W-2:0]         pkt_data
);
  localparam int            DW       = PC_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // classification of the offered event
  logic          c_keep, c_stall, c_addr;
  logic [1:0]    c_id;
  logic [3:0]    c_sub;
  logic [DW-1:0] c_data;

  trc_classify #(.PC_W(PC_W), .EID_W(EID_W)) u_cls (
    .fmt      (cfg_fmt),
    .kind     (ev_kind),
    .addr_hi  (ev_addr),
    .eid      (ev_eid),
    .pc_bits  (cfg_pc_bits),
    .keep     (c_keep),
    .is_stall (c_stall),
    .has_addr (c_addr),
    .id       (c_id),
    .sub      (c_sub),
    .data     (c_data)
  );

  // control state
  logic             act_q;
  logic             end_pend;
  logic [CNT_W-1:0] cnt, cnt_n, cnt_inc;
  logic             last_vld;
  logic [DW-1:0]    last_data;

  // output register interface
  logic          slot_free;
  logic          ld, ld_end, take_addr;
  logic [1:0]    ld_id;
  logic [3:0]    ld_sub;
  logic [DW-1:0] ld_data;

  logic deact, end_req, ev_live, flush;

  assign deact   = act_q && !trace_active;
  assign end_req = deact || end_pend;
  assign ev_live = ev_valid && trace_active;
  assign flush   = (cnt != '0) && (end_req || (ev_live && !c_stall));
  assign cnt_inc = cnt + 1'b1;

  always_comb begin
    ld        = 1'b0;
    ld_end    = 1'b0;
    take_addr = 1'b0;
    ld_id     = PID_EXEC;
    ld_sub    = SUB_NONE;
    ld_data   = '0;
    cnt_n     = cnt;
    ev_ready  = 1'b0;
    if (slot_free) begin
      if (flush) begin
        // pending stall run leaves ahead of whatever comes next
        ld      = 1'b1;
        ld_id   = PID_EXT;
        ld_sub  = SUB_COUNT;
        ld_data = {{(DW-CNT_W){1'b0}}, cnt};
        cnt_n   = '0;
      end else if (end_req) begin
        ld      = 1'b1;
        ld_end  = 1'b1;
        ld_id   = PID_EXT;
        ld_sub  = last_vld ? SUB_END_PC : SUB_END;
        ld_data = last_vld ? last_data : '0;
      end else begin
        ev_ready = 1'b1;
        if (ev_live) begin
          if (c_stall) begin
            if (cnt_inc == CNT_MAX) begin
              ld      = 1'b1;
              ld_id   = PID_EXT;
              ld_sub  = SUB_COUNT;
              ld_data = {{(DW-CNT_W){1'b0}}, CNT_MAX};
              cnt_n   = '0;
            end else begin
              cnt_n = cnt_inc;
            end
          end else if (c_keep) begin
            ld        = 1'b1;
            ld_id     = c_id;
            ld_sub    = c_sub;
            ld_data   = c_data;
            take_addr = c_addr;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      end_pend  <= 1'b0;
      cnt       <= '0;
      last_vld  <= 1'b0;
      last_data <= '0;
    end else begin
      act_q    <= trace_active;
      end_pend <= (end_pend || deact) && !ld_end;
      cnt      <= cnt_n;
      if (ld_end) begin
        last_vld <= 1'b0;
      end else if (take_addr) begin
        last_vld  <= 1'b1;
        last_data <= ld_data;
      end
    end
  end

  trc_out_reg #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld),
    .in_id     (ld_id),
    .in_sub    (ld_sub),
    .in_data   (ld_data),
    .slot_free (slot_free),
    .out_valid (pkt_valid),
    .out_ready (pkt_ready),
    .out_id    (pkt_id),
    .out_sub   (pkt_sub),
    .out_data  (pkt_data)
  );

  assert_plain_no_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_id != PID_EXT) |-> (pkt_sub == SUB_NONE));

  assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_id == PID_EXT && pkt_sub == SUB_COUNT) |-> (pkt_data != '0));

  assert_gate_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !trace_active) |->
      (ld_sub == SUB_COUNT || ld_sub == SUB_END || ld_sub == SUB_END_PC));

  assert_block_events_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |-> !ev_ready);

endmodule

// File: tb/test_trc_encoder.sv
module test_trc_encoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_fmt = 2'd0;
  logic [4:0]  cfg_pc_bits = 5'd31;
  logic        trace_active = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [2:0]  ev_kind = 3'd0;
  logic [31:1] ev_addr = '0;
  logic [7:0]  ev_eid = 8'd0;
  logic        pkt_valid;
  logic        pkt_ready = 1'b1;
  logic [1:0]  pkt_id;
  logic [3:0]  pkt_sub;
  logic [30:0] pkt_data;

  always #5 clk = ~clk;

  trc_encoder #(.PC_W(32), .EID_W(8), .CNT_W(3)) i_trc_encoder (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_pc_bits(cfg_pc_bits),
    .trace_active(trace_active), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_eid(ev_eid),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_id(pkt_id),
    .pkt_sub(pkt_sub), .pkt_data(pkt_data)
  );

  int total = 0;
  int bad   = 0;

  // packet monitor: a transfer seen at the falling edge completes on the next rise
  logic [1:0]  got_id   [64];
  logic [3:0]  got_sub  [64];
  logic [30:0] got_data [64];
  int          got_n = 0;

  always @(negedge clk) begin
    if (rst_n && pkt_valid && pkt_ready && got_n < 64) begin
      got_id[got_n]   = pkt_id;
      got_sub[got_n]  = pkt_sub;
      got_data[got_n] = pkt_data;
      got_n++;
    end
  end

  typedef struct packed {
    logic [1:0]  fmt;
    logic [4:0]  pcb;
    logic [2:0]  kind;
    logic [31:0] addr;
    logic [7:0]  eid;
    logic        n;
    logic [1:0]  id;
    logic [3:0]  sub;
    logic [30:0] data;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd31, 3'd0, 32'h0000_0000, 8'h00, 1'b1, 2'd0, 4'd0, 31'h0},
    '{2'd0, 5'd31, 3'd2, 32'h8000_1234, 8'h00, 1'b1, 2'd2, 4'd0, 31'h4000091A},
    '{2'd0, 5'd8,  3'd2, 32'h0000_1FFE, 8'h00, 1'b1, 2'd2, 4'd0, 31'hFF},
    '{2'd0, 5'd4,  3'd2, 32'h0000_0036, 8'h00, 1'b1, 2'd2, 4'd0, 31'hB},
    '{2'd0, 5'd0,  3'd2, 32'h0000_0003, 8'h00, 1'b1, 2'd2, 4'd0, 31'h1},
    '{2'd0, 5'd31, 3'd3, 32'h0000_0000, 8'h2A, 1'b1, 2'd3, 4'd1, 31'h2A},
    '{2'd0, 5'd31, 3'd4, 32'h0000_0000, 8'h00, 1'b1, 2'd3, 4'd2, 31'h0},
    '{2'd0, 5'd31, 3'd6, 32'h0000_0000, 8'h00, 1'b1, 2'd3, 4'd3, 31'h0},
    '{2'd0, 5'd31, 3'd5, 32'h0000_0000, 8'h00, 1'b1, 2'd3, 4'd4, 31'h0},
    '{2'd0, 5'd31, 3'd7, 32'h0000_1234, 8'h00, 1'b0, 2'd0, 4'd0, 31'h0},
    '{2'd1, 5'd31, 3'd0, 32'h0000_0000, 8'h00, 1'b0, 2'd0, 4'd0, 31'h0},
    '{2'd1, 5'd16, 3'd2, 32'h0000_0100, 8'h00, 1'b1, 2'd2, 4'd0, 31'h80},
    '{2'd1, 5'd31, 3'd3, 32'h0000_0000, 8'h05, 1'b0, 2'd0, 4'd0, 31'h0},
    '{2'd2, 5'd12, 3'd7, 32'h0000_ABCD, 8'h00, 1'b1, 2'd3, 4'd7, 31'h5E6},
    '{2'd2, 5'd31, 3'd2, 32'h0000_0040, 8'h00, 1'b0, 2'd0, 4'd0, 31'h0},
    '{2'd2, 5'd31, 3'd1, 32'h0000_0000, 8'h00, 1'b0, 2'd0, 4'd0, 31'h0},
    '{2'd3, 5'd31, 3'd2, 32'h0000_0040, 8'h00, 1'b0, 2'd0, 4'd0, 31'h0},
    '{2'd1, 5'd31, 3'd1, 32'h0000_0000, 8'h00, 1'b0, 2'd0, 4'd0, 31'h0}
  };

  function automatic string vec_req(vec_t v);
    if (v.fmt == 2'd1) return "R6";
    if (v.fmt == 2'd2) return "R7";
    if (v.fmt == 2'd3) return "R11";
    if (v.kind == 3'd2) return "R3";
    if (v.kind >= 3'd3) return "R4";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_pkt(input int idx, input logic [1:0] id, input logic [3:0] sub,
                         input logic [30:0] data, input string req);
    if (idx >= got_n) begin
      chk(1'b0, req, "packet missing", 32'(got_n), 32'(idx + 1));
    end else begin
      chk(got_id[idx] == id && got_sub[idx] == sub && got_data[idx] == data, req,
          "packet id/sub/data",
          {got_id[idx], got_sub[idx], 26'(got_data[idx])},
          {id, sub, 26'(data)});
      if (got_data[idx] != data)
        chk(1'b0, req, "packet data", 32'(got_data[idx]), 32'(data));
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [31:0] a, input logic [7:0] e);
    @(negedge clk);
    ev_kind  = k;
    ev_addr  = a[31:1];
    ev_eid   = e;
    ev_valid = 1'b1;
    forever begin
      #1;
      if (ev_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 ev_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic set_active(input logic v);
    @(negedge clk);
    trace_active = v;
    settle();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(pkt_valid == 1'b0, "R1", "pkt_valid after reset", 32'(pkt_valid), 32'd0);
    chk(ev_ready == 1'b1, "R1", "ev_ready after reset", 32'(ev_ready), 32'd1);

    set_active(1'b1);

    // table walk: one event per vector, zero or one packet each
    for (int v = 0; v < NV; v++) begin
      base = got_n;
      @(negedge clk);
      cfg_fmt     = VECS[v].fmt;
      cfg_pc_bits = VECS[v].pcb;
      send(VECS[v].kind, VECS[v].addr, VECS[v].eid);
      settle();
      chk(got_n - base == int'(VECS[v].n), vec_req(VECS[v]), $sformatf("packet count vec %0d", v),
          32'(got_n - base), 32'(VECS[v].n));
      if (VECS[v].n)
        chk_pkt(base, VECS[v].id, VECS[v].sub, VECS[v].data, vec_req(VECS[v]));
    end

    // R9: last recorded address was the cache miss, so end carries it
    base = got_n;
    set_active(1'b0);
    chk(got_n - base == 1, "R9", "end packet count", 32'(got_n - base), 32'd1);
    chk_pkt(base, 2'd3, 4'd10, 31'h5E6, "R9");

    // R5: stall run merged into one count packet ahead of the next event
    @(negedge clk);
    cfg_fmt = 2'd0;
    cfg_pc_bits = 5'd31;
    set_active(1'b1);
    base = got_n;
    for (int i = 0; i < 3; i++) send(3'd1, 32'h0, 8'h0);
    settle();
    chk(got_n == base, "R5", "no packet during stall run", 32'(got_n - base), 32'd0);
    send(3'd0, 32'h0, 8'h0);
    settle();
    chk(got_n - base == 2, "R5", "count+exec packets", 32'(got_n - base), 32'd2);
    chk_pkt(base, 2'd3, 4'd6, 31'd3, "R5");
    chk_pkt(base + 1, 2'd0, 4'd0, 31'd0, "R5");

    // R5: saturating run flushes at 7 without a following event
    base = got_n;
    for (int i = 0; i < 7; i++) send(3'd1, 32'h0, 8'h0);
    settle();
    chk(got_n - base == 1, "R5", "saturated count emitted", 32'(got_n - base), 32'd1);
    chk_pkt(base, 2'd3, 4'd6, 31'd7, "R5");

    // R9 + R5: partial run flushed before a plain end
    base = got_n;
    send(3'd1, 32'h0, 8'h0);
    send(3'd1, 32'h0, 8'h0);
    set_active(1'b0);
    chk(got_n - base == 2, "R9", "count then end", 32'(got_n - base), 32'd2);
    chk_pkt(base, 2'd3, 4'd6, 31'd2, "R5");
    chk_pkt(base + 1, 2'd3, 4'd9, 31'd0, "R9");

    // R8: inactive events consumed silently, stalls not carried over
    base = got_n;
    send(3'd0, 32'h0, 8'h0);
    send(3'd2, 32'h44, 8'h0);
    send(3'd1, 32'h0, 8'h0);
    settle();
    chk(got_n == base, "R8", "no packets while inactive", 32'(got_n - base), 32'd0);
    set_active(1'b1);
    send(3'd0, 32'h0, 8'h0);
    settle();
    chk(got_n - base == 1, "R8", "no stale count after activation", 32'(got_n - base), 32'd1);
    chk_pkt(base, 2'd0, 4'd0, 31'd0, "R8");

    // R10: back-pressure holds the packet and blocks the next event
    base = got_n;
    @(posedge clk);
    #1 pkt_ready = 1'b0;
    send(3'd0, 32'h0, 8'h0);
    @(negedge clk);
    ev_kind = 3'd2;
    ev_addr = 31'h8;
    ev_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk(ev_ready == 1'b0, "R10", "ev_ready while blocked", 32'(ev_ready), 32'd0);
      chk(pkt_valid && pkt_id == 2'd0, "R10", "held packet", {30'd0, pkt_valid, pkt_id[0]}, 32'd2);
    end
    @(posedge clk);
    #1 pkt_ready = 1'b1;
    forever begin
      @(negedge clk);
      #1;
      if (ev_ready) break;
    end
    @(posedge clk);
    #1 ev_valid = 1'b0;
    settle();
    chk(got_n - base == 2, "R10", "both packets delivered", 32'(got_n - base), 32'd2);
    chk_pkt(base, 2'd0, 4'd0, 31'd0, "R10");
    chk_pkt(base + 1, 2'd2, 4'd0, 31'h8, "R10");

    // R9: end with the branch address just recorded
    base = got_n;
    set_active(1'b0);
    chk_pkt(base, 2'd3, 4'd10, 31'h8, "R9");

    finish_run();
  end

endmodule